// File: doc/BRIEF.md
# Compute Queue Assignment Scheduler

This block sits between software that creates compute queues and a set of compute engines that run them. Each engine owns a fixed number of hardware queue slots. New queue descriptors arrive with a priority and wait in a small pending buffer. Whenever at least one slot anywhere is free and the buffer is not empty, the scheduler places one buffered queue per clock into a free slot. It keeps doing so until either every slot is occupied or nothing is left to place.

The highest-priority pending queue goes first. Among queues of equal priority, the one that arrived first goes first. The free slot chosen is the one with the lowest engine number, and within that engine the lowest slot number. A queue that already holds a slot keeps it until its engine reports the slot finished. A newly arrived urgent queue never displaces a running one. An engine reports a finished slot on the release port. That slot can be handed to a waiting queue on the same clock edge that clears it.

Top module: `cq_assign_sched`

## Requirements
- R1: After reset, no assignment is presented (`asg_valid` low), all slots are free, the buffer is empty and `push_full` is low.
- R2: The buffer holds up to 16 descriptors. `push_full` is high exactly when 16 are held. A push offered while `push_full` is high is dropped and never assigned.
- R3: A queue pushed while a slot is free appears on the assignment output one edge after the edge that accepts it. At most one assignment is made per clock cycle.
- R4: Priority is an unsigned 2-bit value, and a larger value means more urgent. The most urgent pending queue is assigned first.
- R5: Among pending queues of equal priority, the earliest pushed is assigned first.
- R6: The free slot chosen is the lowest flat index {engine, slot}: engine 0 first, and within an engine slot 0 first. `asg_eng`/`asg_slot` report that slot and `asg_desc` the descriptor placed in it.
- R7: While every slot is occupied, no assignment is made and pending queues stay buffered in order.
- R8: A release marks the named slot free from the edge that samples it. If queues are pending, an assignment is made at that same edge. A release of a slot that is already free has no effect.
- R9: When a release and an assignment name the same slot in one cycle, the slot ends up occupied by the new queue.
- R10: An occupied slot is never assigned again until it has been released. Running queues are never evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Offer a new queue descriptor |
| push_prio | input | 2 | Priority of the offered queue (larger is more urgent) |
| push_desc | input | 16 | Queue descriptor |
| push_full | output | 1 | Buffer holds 16 entries; pushes are dropped |
| rel_valid | input | 1 | An engine reports a finished slot |
| rel_eng | input | 3 | Engine of the finished slot |
| rel_slot | input | 3 | Slot index within that engine |
| asg_valid | output | 1 | An assignment was made at the last edge |
| asg_eng | output | 3 | Engine receiving the queue |
| asg_slot | output | 3 | Slot within that engine |
| asg_desc | output | 16 | Descriptor placed in the slot |

## Verification
Each result has a fixed arrival time. A release sampled at an edge produces its assignment on the registered outputs right after that same edge. A push reaches the outputs one edge later, because it first has to enter the buffer. `push_full` reflects the buffer count registered at the previous edge. The bench drives every input at the falling edge and advances a per-cycle model of the slots and the ordered buffer by one edge. It then compares the outputs at the next falling edge, so every expected value is aligned to the edge that produces it.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
  localparam int unsigned CQS_ENGINES     = 8;
  localparam int unsigned CQS_SLOTS       = 8;
  localparam int unsigned CQS_BUF_DEPTH   = 16;
  localparam int unsigned CQS_PRIO_W      = 2;
  localparam int unsigned CQS_DESC_W      = 16;
endpackage

// File: rtl/cqs_pend_buf.sv
// Age-ordered pending buffer: entry 0 is the oldest. The pick logic selects
// the most urgent entry, lowest index (oldest) on ties; removal compacts.
module cqs_pend_buf #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned DESC_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [DESC_W-1:0] push_desc,
  input  logic              pop_en,
  output logic [DESC_W-1:0] pick_desc,
  output logic              not_empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [DESC_W-1:0] desc_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  pick_idx;
  logic [PRIO_W-1:0] pick_prio;
  logic              pick_found;
  logic              push_acc;
  logic              pop_act;
  logic [CNT_W-1:0]  wr_pos;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign count     = cnt_q;
  assign push_acc  = push_en && !full;
  assign pop_act   = pop_en && not_empty;
  assign wr_pos    = cnt_q - (pop_act ? CNT_W'(1) : CNT_W'(0));

  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    pick_prio  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt_q) begin
        if (!pick_found || (prio_q[i] > pick_prio)) begin
          pick_found = 1'b1;
          pick_idx   = PTR_W'(i);
          pick_prio  = prio_q[i];
        end
      end
    end
  end

  assign pick_desc = desc_q[pick_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic shift_in;
    assign shift_in = pop_act && (PTR_W'(g) >= pick_idx);
    always_ff @(posedge clk) begin
      if (push_acc && (CNT_W'(g) == wr_pos)) begin
        prio_q[g] <= push_prio;
        desc_q[g] <= push_desc;
      end else if (shift_in) begin
        if (g < DEPTH - 1) begin
          prio_q[g] <= prio_q[(g < DEPTH - 1) ? g + 1 : g];
          desc_q[g] <= desc_q[(g < DEPTH - 1) ? g + 1 : g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + (push_acc ? CNT_W'(1) : CNT_W'(0))
                     - (pop_act  ? CNT_W'(1) : CNT_W'(0));
    end
  end
endmodule

// File: rtl/cqs_slot_map.sv
// Occupancy of all slots, flat index {engine, slot}. A release in the current
// cycle counts as free for the search; a take wins over a release.
module cqs_slot_map #(
  parameter int unsigned NUM_SLOTS = 64,
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rel_en,
  input  logic [IDX_W-1:0]     rel_idx,
  input  logic                 take_en,
  input  logic [IDX_W-1:0]     take_idx,
  output logic [NUM_SLOTS-1:0] occ,
  output logic                 free_any,
  output logic [IDX_W-1:0]     free_idx
);
  logic [NUM_SLOTS-1:0] occ_q;
  logic [NUM_SLOTS-1:0] rel_mask;
  logic [NUM_SLOTS-1:0] take_mask;
  logic [NUM_SLOTS-1:0] avail;

  assign rel_mask  = rel_en  ? (NUM_SLOTS'(1) << rel_idx)  : '0;
  assign take_mask = take_en ? (NUM_SLOTS'(1) << take_idx) : '0;
  assign avail     = ~occ_q | rel_mask;
  assign occ       = occ_q;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (avail[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= (occ_q & ~rel_mask) | take_mask;
  end
endmodule

// File: rtl/cq_assign_sched.sv
module cq_assign_sched #(
  parameter int unsigned NUM_ENG   = cqs_pkg::CQS_ENGINES,
  parameter int unsigned SLOTS     = cqs_pkg::CQS_SLOTS,
  parameter int unsigned BUF_DEPTH = cqs_pkg::CQS_BUF_DEPTH,
  parameter int unsigned PRIO_W    = cqs_pkg::CQS_PRIO_W,
  parameter int unsigned DESC_W    = cqs_pkg::CQS_DESC_W,
  localparam int unsigned ENG_W    = $clog2(NUM_ENG),
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned TOTAL    = NUM_ENG * SLOTS,
  localparam int unsigned IDX_W    = ENG_W + SLOT_W,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [DESC_W-1:0] push_desc,
  output logic              push_full,
  input  logic              rel_valid,
  input  logic [ENG_W-1:0]  rel_eng,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              asg_valid,
  output logic [ENG_W-1:0]  asg_eng,
  output logic [SLOT_W-1:0] asg_slot,
  output logic [DESC_W-1:0] asg_desc
);
  logic [DESC_W-1:0] pick_desc;
  logic              buf_has;
  logic [CNT_W-1:0]  buf_cnt;
  logic [TOTAL-1:0]  occ_vec;
  logic              slot_free;
  logic [IDX_W-1:0]  slot_idx;
  logic              take;

  assign take = buf_has && slot_free;

  cqs_pend_buf #(
    .DEPTH(BUF_DEPTH), .PRIO_W(PRIO_W), .DESC_W(DESC_W)
  ) pend_i (
    .clk(clk), .rst(rst),
    .push_en(push_valid), .push_prio(push_prio), .push_desc(push_desc),
    .pop_en(take), .pick_desc(pick_desc), .not_empty(buf_has),
    .full(push_full), .count(buf_cnt)
  );

  cqs_slot_map #(.NUM_SLOTS(TOTAL)) slots_i (
    .clk(clk), .rst(rst),
    .rel_en(rel_valid), .rel_idx({rel_eng, rel_slot}),
    .take_en(take), .take_idx(slot_idx),
    .occ(occ_vec), .free_any(slot_free), .free_idx(slot_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      asg_valid <= 1'b0;
      asg_eng   <= '0;
      asg_slot  <= '0;
      asg_desc  <= '0;
    end else begin
      asg_valid <= take;
      if (take) begin
        asg_eng  <= slot_idx[IDX_W-1:SLOT_W];
        asg_slot <= slot_idx[SLOT_W-1:0];
        asg_desc <= pick_desc;
      end
    end
  end
endmodule

// File: rtl/cq_assign_sched_chk.sv
module cq_assign_sched_chk #(
  parameter int unsigned TOTAL     = 64,
  parameter int unsigned BUF_DEPTH = 16,
  parameter int unsigned ENG_W     = 3,
  parameter int unsigned SLOT_W    = 3,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_valid,
  input logic              push_full,
  input logic              asg_valid,
  input logic [ENG_W-1:0]  asg_eng,
  input logic [SLOT_W-1:0] asg_slot,
  input logic [TOTAL-1:0]  occ,
  input logic [CNT_W-1:0]  cnt
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BUF_DEPTH));

  assert_full_after_push_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(push_full) |-> $past(push_valid));

  assert_slot_now_taken_R10: assert property (@(posedge clk) disable iff (rst)
    asg_valid |-> occ[{asg_eng, asg_slot}]);

  assert_no_empty_pick_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !asg_valid);

  assert_work_conserving_R7: assert property (@(posedge clk) disable iff (rst)
    ((cnt != '0) && !(&occ)) |=> asg_valid);
endmodule

bind cq_assign_sched cq_assign_sched_chk #(
  .TOTAL(TOTAL), .BUF_DEPTH(BUF_DEPTH), .ENG_W(ENG_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst(rst), .push_valid(push_valid), .push_full(push_full),
  .asg_valid(asg_valid), .asg_eng(asg_eng), .asg_slot(asg_slot),
  .occ(occ_vec), .cnt(buf_cnt)
);

// File: tb/cq_assign_sched_tb_top.sv
module cq_assign_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        push_valid;
  logic [1:0]  push_prio;
  logic [15:0] push_desc;
  logic        push_full;
  logic        rel_valid;
  logic [2:0]  rel_eng;
  logic [2:0]  rel_slot;
  logic        asg_valid;
  logic [2:0]  asg_eng;
  logic [2:0]  asg_slot;
  logic [15:0] asg_desc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [63:0] m_occ;
  logic [1:0]  m_prio [16];
  logic [15:0] m_desc [16];
  int          m_cnt;

  always #2 clk = ~clk;

  cq_assign_sched dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_prio(push_prio),
    .push_desc(push_desc), .push_full(push_full), .rel_valid(rel_valid),
    .rel_eng(rel_eng), .rel_slot(rel_slot), .asg_valid(asg_valid),
    .asg_eng(asg_eng), .asg_slot(asg_slot), .asg_desc(asg_desc)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Called at a falling edge; drives inputs for one cycle and checks results.
  task automatic step(input bit pv, input logic [1:0] pp, input logic [15:0] pd,
                      input bit rv, input int re, input int rs, input string tag);
    logic [63:0] rmask, avail;
    int fi, bi, old_cnt;
    bit take;
    logic [15:0] e_desc;
    push_valid = pv; push_prio = pp; push_desc = pd;
    rel_valid = rv; rel_eng = 3'(re); rel_slot = 3'(rs);
    rmask = rv ? (64'd1 << (re * 8 + rs)) : 64'd0;
    avail = ~m_occ | rmask;
    fi = -1;
    for (int i = 63; i >= 0; i--) if (avail[i]) fi = i;
    take = (m_cnt > 0) && (fi >= 0);
    bi = 0; e_desc = '0;
    old_cnt = m_cnt;
    if (take) begin
      for (int i = 1; i < m_cnt; i++) if (m_prio[i] > m_prio[bi]) bi = i;
      e_desc = m_desc[bi];
      for (int i = bi; i < m_cnt - 1; i++) begin
        m_prio[i] = m_prio[i + 1]; m_desc[i] = m_desc[i + 1];
      end
      m_cnt--;
    end
    if (pv && old_cnt < 16) begin
      m_prio[m_cnt] = pp; m_desc[m_cnt] = pd; m_cnt++;
    end
    m_occ = (m_occ & ~rmask) | (take ? (64'd1 << fi) : 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(asg_valid == take, tag, "asg_valid", int'(asg_valid), int'(take));
    if (take && asg_valid) begin
      check({asg_eng, asg_slot} == 6'(fi), tag, "slot index",
            int'({asg_eng, asg_slot}), fi);
      check(asg_desc == e_desc, tag, "asg_desc", int'(asg_desc), int'(e_desc));
    end
    check(push_full == (m_cnt == 16), tag, "push_full", int'(push_full),
          int'(m_cnt == 16));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd0, 16'd0, 1'b0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst = 1'b1; push_valid = 0; push_prio = 0; push_desc = 0;
    rel_valid = 0; rel_eng = 0; rel_slot = 0;
    m_occ = '0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(asg_valid == 1'b0, "R1", "asg_valid", int'(asg_valid), 0);
    check(push_full == 1'b0, "R1", "push_full", int'(push_full), 0);
    idle("R1");

    // R3 / R6: first push goes to engine 0 slot 0 one edge after acceptance
    step(1'b1, 2'd1, 16'hA000, 1'b0, 0, 0, "R3");
    idle("R6");
    // fill the remaining 63 slots, one push per cycle, in slot order
    for (int k = 1; k < 64; k++)
      step(1'b1, 2'($urandom_range(3)), 16'hA000 + 16'(k), 1'b0, 0, 0, "R6");
    idle("R6");

    // R2: 17 pushes while all slots are busy; the last is dropped
    for (int k = 0; k < 17; k++) begin
      logic [1:0] p;
      p = (k % 5 == 2) ? 2'd3 : ((k % 3 == 0) ? 2'd2 : 2'd0);
      step(1'b1, p, 16'hB000 + 16'(k), 1'b0, 0, 0, "R2");
    end
    // R7: nothing is placed while everything is occupied
    idle("R7");
    idle("R10");

    // R8 / R4 / R5: single releases place the most urgent, oldest queue
    step(1'b0, 2'd0, 16'd0, 1'b1, 3, 5, "R8");
    step(1'b0, 2'd0, 16'd0, 1'b1, 6, 1, "R4");
    step(1'b0, 2'd0, 16'd0, 1'b1, 0, 7, "R5");
    // R9: release the slot just refilled; it is reassigned at the same edge
    step(1'b0, 2'd0, 16'd0, 1'b1, 0, 7, "R9");
    step(1'b0, 2'd0, 16'd0, 1'b1, 0, 7, "R9");
    idle("R10");
    // drain the buffer through repeated releases of other slots
    for (int k = 0; k < 14; k++)
      step(1'b0, 2'd0, 16'd0, 1'b1, k % 8, (k * 3) % 8, "R5");
    idle("R7");
    // R8: release with the buffer empty, then a redundant release of the same slot
    step(1'b0, 2'd0, 16'd0, 1'b1, 7, 7, "R8");
    step(1'b0, 2'd0, 16'd0, 1'b1, 7, 7, "R8");
    step(1'b1, 2'd2, 16'hC001, 1'b0, 0, 0, "R8");
    idle("R8");

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      bit pv, rv;
      pv = ($urandom_range(99) < 55);
      rv = ($urandom_range(99) < 50);
      step(pv, 2'($urandom_range(3)), 16'($urandom), rv,
           int'($urandom_range(7)), int'($urandom_range(7)), "R3");
    end
    for (int k = 0; k < 8; k++) idle("R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule